// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block is the timekeeping core of a real-time clock. It holds seven packed-BCD bytes (seconds, minutes, hours, day of week, date, month and a two-digit year). A once-per-second `tick_1hz` enable moves time forward by one second, with carries passing up through the whole calendar. Hours run in either a 24-hour or a 12-hour format. The format is chosen by a bit in the hours byte. The date wraps at the true end of each month, and February has 29 days in leap years.

Software or a bus bridge loads any of the seven bytes through a single-cycle write port. The port has no handshake: a write is always accepted in the cycle `wr_en` is high, so it never applies back-pressure. All seven bytes are readable in parallel at all times. A halt bit in the seconds byte freezes counting. A write to the seconds byte raises `presc_restart` for one cycle, so the external sub-second divider can restart its count and deliver the next tick a full second later.

Top module: `bcal_core`

## Requirements
- R1: After reset the bytes read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01, year 0x00, and `presc_restart` is 0.
- R2: While running, each `tick_1hz` advances seconds by one in BCD. Seconds and minutes each count 00 to 59, and each wrap to 00 passes a carry to the next field.
- R3: When seconds bit 7 (halt) is 1, `tick_1hz` changes no byte.
- R4: With hours bit 6 = 0, hours count 00 to 23 in BCD, with bit 5 holding the tens digit 2. The step from 23 to 00 advances the calendar by one day.
- R5: With hours bit 6 = 1, bit 5 = 1 means PM and bits 4:0 hold 01 to 12 in BCD. The sequence is 11 AM to 12 PM, 12 PM to 1 PM, 11 PM to 12 AM and 12 AM to 1 AM. The calendar advances only on the 11 PM to 12 AM step.
- R6: Day of week counts 1 to 7 and goes from 7 back to 1 on each day advance.
- R7: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other long months, and after day 28 in February. In February of a year whose value is a multiple of 4 (00 included), the date wraps after day 29 instead. Each date wrap advances the month.
- R8: Month goes from 12 to 01 and advances the year. Year goes from 99 to 00.
- R9: Write address encoding is 0 = seconds, 1 = minutes, 2 = hours, 3 = day of week, 4 = date, 5 = month, 6 = year. Address 7 changes nothing. A write stores the byte with its reserved bits cleared: minutes bit 7, hours bit 7, day-of-week bits 7:3, date bits 7:6 and month bits 7:5.
- R10: A seconds write asserts `presc_restart` in the following cycle only. A tick in the same cycle as that write has no effect on any byte.
- R11: A write to a byte other than seconds, made in the same cycle as a tick, leaves the written value in that byte. The other bytes advance as the tick dictates.
- R12: With no tick and no write, every byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Byte write strobe, always accepted |
| wr_addr | input | 3 | Byte select for the write |
| wr_data | input | 8 | Byte to store |
| sec_o | output | 8 | Halt bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Mode bit, AM/PM or tens-of-20 bit, and BCD hours |
| dow_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| presc_restart | output | 1 | Pulse telling the sub-second divider to start over |

## Verification
A tick and a byte write can arrive in the same cycle. The bench provokes this by asserting both strobes on one edge. In one case the target is seconds, and every byte must stay exactly as written, with no advance. In the other case a higher byte is written while seconds wrap, and the written byte must hold its new value while seconds still roll to 00. Calendar boundaries are swept over every month of every year, and a whole day is run tick by tick against an arithmetic seconds count.

// File: rtl/bcal_pkg.sv
package bcal_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_REGS = 7;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  // Bits that may hold a value in each byte, indexed by address
  localparam logic [BYTE_W-1:0] KEEP_MASK [NUM_REGS] =
    '{8'hFF, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

  function automatic logic [BYTE_W-1:0] bcd_next(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4: even tens with units 0/4/8, odd tens with 2/6
  function automatic logic leap_year(input logic [BYTE_W-1:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [BYTE_W-1:0] month_end(input logic [BYTE_W-1:0] m,
                                                   input logic [BYTE_W-1:0] y);
    case (m)
      8'h02: return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcal_time_chain.sv
module bcal_time_chain
  import bcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_sec,
  input  logic              wr_min,
  input  logic              wr_hour,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] sec_q,
  output logic [BYTE_W-1:0] min_q,
  output logic [BYTE_W-1:0] hour_q,
  output logic              day_carry
);
  logic              sec_wrap, min_wrap;
  logic [BYTE_W-1:0] sec_nx, min_nx, hour_nx;

  always_comb begin
    sec_wrap = step && (sec_q[6:0] == 7'h59);
    min_wrap = sec_wrap && (min_q == 8'h59);
    sec_nx   = sec_wrap ? {sec_q[7], 7'h00} : bcd_next(sec_q);
    min_nx   = (min_q == 8'h59) ? 8'h00 : bcd_next(min_q);
    hour_nx  = hour_q;
    day_carry = 1'b0;
    if (hour_q[6]) begin
      // 12-hour: bit5 PM, bits 4:0 hold 01..12
      if (hour_q[4:0] == 5'h12) begin
        hour_nx = {hour_q[7:5], 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hour_nx   = {hour_q[7:6], ~hour_q[5], 5'h12};
        day_carry = min_wrap && hour_q[5];
      end else begin
        hour_nx = {hour_q[7:5], 5'(bcd_next({3'd0, hour_q[4:0]}))};
      end
    end else begin
      if (hour_q[5:0] == 6'h23) begin
        hour_nx   = 8'h00;
        day_carry = min_wrap;
      end else begin
        hour_nx = bcd_next(hour_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else begin
      if (wr_sec)        sec_q  <= wr_data & KEEP_MASK[SEL_SEC];
      else if (step)     sec_q  <= sec_nx;
      if (wr_min)        min_q  <= wr_data & KEEP_MASK[SEL_MIN];
      else if (sec_wrap) min_q  <= min_nx;
      if (wr_hour)       hour_q <= wr_data & KEEP_MASK[SEL_HOUR];
      else if (min_wrap) hour_q <= hour_nx;
    end
  end
endmodule

// File: rtl/bcal_date_chain.sv
module bcal_date_chain
  import bcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_step,
  input  logic              wr_dow,
  input  logic              wr_date,
  input  logic              wr_month,
  input  logic              wr_year,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] dow_q,
  output logic [BYTE_W-1:0] date_q,
  output logic [BYTE_W-1:0] month_q,
  output logic [BYTE_W-1:0] year_q
);
  logic month_step, year_step;

  always_comb begin
    month_step = day_step && (date_q == month_end(month_q, year_q));
    year_step  = month_step && (month_q == 8'h12);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_dow)          dow_q   <= wr_data & KEEP_MASK[SEL_DOW];
      else if (day_step)   dow_q   <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      if (wr_date)         date_q  <= wr_data & KEEP_MASK[SEL_DATE];
      else if (day_step)   date_q  <= month_step ? 8'h01 : bcd_next(date_q);
      if (wr_month)        month_q <= wr_data & KEEP_MASK[SEL_MONTH];
      else if (month_step) month_q <= year_step ? 8'h01 : bcd_next(month_q);
      if (wr_year)         year_q  <= wr_data & KEEP_MASK[SEL_YEAR];
      else if (year_step)  year_q  <= (year_q == 8'h99) ? 8'h00 : bcd_next(year_q);
    end
  end
endmodule

// File: rtl/bcal_core.sv
module bcal_core
  import bcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [BYTE_W-1:0] dow_o,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o,
  output logic              presc_restart
);
  logic [NUM_REGS-1:0] wr_hit;
  logic                step, day_carry;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  // A seconds write restarts the second, so it swallows a coincident tick
  assign step = tick_1hz && !sec_o[7] && !wr_hit[SEL_SEC];

  bcal_time_chain u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .wr_sec   (wr_hit[SEL_SEC]),
    .wr_min   (wr_hit[SEL_MIN]),
    .wr_hour  (wr_hit[SEL_HOUR]),
    .wr_data  (wr_data),
    .sec_q    (sec_o),
    .min_q    (min_o),
    .hour_q   (hour_o),
    .day_carry(day_carry)
  );

  bcal_date_chain u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .day_step(day_carry),
    .wr_dow  (wr_hit[SEL_DOW]),
    .wr_date (wr_hit[SEL_DATE]),
    .wr_month(wr_hit[SEL_MONTH]),
    .wr_year (wr_hit[SEL_YEAR]),
    .wr_data (wr_data),
    .dow_q   (dow_o),
    .date_q  (date_o),
    .month_q (month_o),
    .year_q  (year_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_restart <= 1'b0;
    else        presc_restart <= wr_hit[SEL_SEC];
  end
endmodule

// File: rtl/bcal_core_checks.sv
module bcal_core_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       presc_restart
);
  a_r3_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en) |=> $stable(sec_o));

  a_r10_restart_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> presc_restart);

  a_r10_restart_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    presc_restart |-> $past(wr_en && wr_addr == 3'd0));

  a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[6:0] <= 7'h59 && min_o <= 8'h59);

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_en && !sec_o[7] && sec_o[6:0] == 7'h59) |=> sec_o[6:0] == 7'h00);

  a_r6_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    dow_o >= 8'h01 && dow_o <= 8'h07);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !min_o[7] && !hour_o[7] && dow_o[7:3] == 5'd0 && date_o[7:6] == 2'd0 && month_o[7:5] == 3'd0);

  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !wr_en) |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o}));
endmodule

bind bcal_core bcal_core_checks u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_1hz     (tick_1hz),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .sec_o        (sec_o),
  .min_o        (min_o),
  .hour_o       (hour_o),
  .dow_o        (dow_o),
  .date_o       (date_o),
  .month_o      (month_o),
  .year_o       (year_o),
  .presc_restart(presc_restart)
);

// File: tb/tb_bcal_core.sv
module tb_bcal_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       presc_restart;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bcal_core dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int days_of(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] h12(input int h);
    int hr;
    hr = (h % 12 == 0) ? 12 : h % 12;
    return 8'h40 | (h >= 12 ? 8'h20 : 8'h00) | bcd(hr);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle with optional write and tick; returns at the following negedge
  task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d, input logic t);
    wr_en = we; wr_addr = a; wr_data = d; tick_1hz = t;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic set_all(input logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sec", sec_o, 8'h00);   check("R1 min", min_o, 8'h00);
    check("R1 hour", hour_o, 8'h00); check("R1 dow", dow_o, 8'h01);
    check("R1 date", date_o, 8'h01); check("R1 month", month_o, 8'h01);
    check("R1 year", year_o, 8'h00); check("R1 restart", {7'd0, presc_restart}, 8'h00);

    // R12 idle holds
    repeat (5) @(negedge clk);
    check("R12 idle sec", sec_o, 8'h00);
    check("R12 idle dow", dow_o, 8'h01);

    // R2 R4 full 24-hour day, tick every cycle
    tick_1hz = 1'b1;
    for (int i = 1; i <= 86400; i++) begin
      @(negedge clk);
      if (i % 97 == 0 || i % 3600 == 0 || i == 86400 || i == 86399) begin
        check("R2 sec", sec_o, bcd(i % 60));
        check("R2 min", min_o, bcd((i / 60) % 60));
        check("R4 hour", hour_o, bcd((i / 3600) % 24));
      end
    end
    tick_1hz = 1'b0;
    check("R4 day advance dow", dow_o, 8'h02);
    check("R4 day advance date", date_o, 8'h02);

    // R5 12-hour sweep over every hour boundary
    for (int h = 0; h < 24; h++) begin
      set_all(8'h59, 8'h59, h12(h), 8'h03, 8'h10, 8'h05, 8'h21);
      cyc(1'b0, 3'd0, 8'h00, 1'b1);
      check("R5 hour12", hour_o, h12((h + 1) % 24));
      check("R5 day carry dow", dow_o, (h == 23) ? 8'h04 : 8'h03);
      check("R5 day carry date", date_o, (h == 23) ? 8'h11 : 8'h10);
    end

    // R6 day-of-week wrap
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h05, 8'h03, 8'h10);
    cyc(1'b0, 3'd0, 8'h00, 1'b1);
    check("R6 dow wrap", dow_o, 8'h01);

    // R7 R8 end of every month in every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_all(8'h59, 8'h59, 8'h23, 8'h02, bcd(days_of(m, y)), bcd(m), bcd(y));
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
        check("R7 date wrap", date_o, 8'h01);
        check("R8 month", month_o, bcd(m == 12 ? 1 : m + 1));
        check("R8 year", year_o, bcd(m == 12 ? (y + 1) % 100 : y));
      end
      // R7 Feb 28 does not wrap in leap years
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, bcd(y));
      cyc(1'b0, 3'd0, 8'h00, 1'b1);
      check("R7 feb28", date_o, (y % 4 == 0) ? 8'h29 : 8'h01);
    end

    // R3 halt
    set_all(8'hB0, 8'h20, 8'h10, 8'h04, 8'h15, 8'h06, 8'h33);
    for (int k = 0; k < 4; k++) cyc(1'b0, 3'd0, 8'h00, 1'b1);
    check("R3 halted sec", sec_o, 8'hB0);
    check("R3 halted min", min_o, 8'h20);
    wr(3'd0, 8'h30);
    cyc(1'b0, 3'd0, 8'h00, 1'b1);
    check("R3 resumed", sec_o, 8'h31);

    // R9 masking and address 7
    set_all(8'h00, 8'hA5, 8'h92, 8'hF3, 8'hC7, 8'hE9, 8'h42);
    check("R9 min mask", min_o, 8'h25);   check("R9 hour mask", hour_o, 8'h12);
    check("R9 dow mask", dow_o, 8'h03);   check("R9 date mask", date_o, 8'h07);
    check("R9 month mask", month_o, 8'h09); check("R9 year", year_o, 8'h42);
    wr(3'd7, 8'h55);
    check("R9 addr7 sec", sec_o, 8'h00);  check("R9 addr7 year", year_o, 8'h42);
    check("R9 addr7 min", min_o, 8'h25);

    // R10 seconds write with a coincident tick
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    cyc(1'b1, 3'd0, 8'h12, 1'b1);
    check("R10 sec written", sec_o, 8'h12);
    check("R10 restart pulse", {7'd0, presc_restart}, 8'h01);
    check("R10 no advance min", min_o, 8'h59);
    @(negedge clk);
    check("R10 restart one cycle", {7'd0, presc_restart}, 8'h00);

    // R11 minutes write while seconds wrap
    set_all(8'h59, 8'h10, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00);
    cyc(1'b1, 3'd1, 8'h45, 1'b1);
    check("R11 min written", min_o, 8'h45);
    check("R11 sec advanced", sec_o, 8'h00);
    check("R11 restart idle", {7'd0, presc_restart}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule